// File: doc/BRIEF.md
# Second-Operand Shifter and Decoder

This block builds the second ALU operand of a 32-bit processor datapath from a 12-bit operand field. It has no state. With the immediate select high, the low byte of the field is treated as a literal. The literal is zero-extended and rotated right by twice the 4-bit count held in the top nibble. With the select low, the register value `rm_i` passes through a barrel shifter. The shift kind comes from field bits 6:5. The amount comes either from field bits 11:7 or from the low five bits of `rs_i`, as chosen by field bit 4.

The block also produces a shifter carry-out for the flag logic downstream. It decodes the zero-amount immediate encodings that mean something other than "no shift". It raises a flag when the field cannot be a shifted-register operand. Reading the register file, the ALU itself and flag write-back are handled outside this block.

Top module: `operand_shifter`

## Requirements
- R1: When imm_sel_i=1, operand_o equals field_i[7:0] zero-extended to 32 bits and rotated right by 2*field_i[11:8] bits.
- R2: When imm_sel_i=1, carry_o equals carry_i if field_i[11:8]=0, and otherwise equals operand_o[31].
- R3: When imm_sel_i=0, field_i[6:5] picks the shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. With field_i[4]=0 the amount is field_i[11:7], and a nonzero amount shifts rm_i by that many bits.
- R4: For a nonzero shift amount, carry_o is the last bit shifted out. That is rm_i[32-n] for a left shift, and rm_i[n-1] for a right shift or a rotate.
- R5: Logical left with immediate amount 0 gives operand_o=rm_i and carry_o=carry_i.
- R6: Logical right with immediate amount 0 acts as a shift by 32: operand_o=0 and carry_o=rm_i[31].
- R7: Arithmetic right with immediate amount 0 acts as a shift by 32: every bit of operand_o equals rm_i[31], and carry_o=rm_i[31].
- R8: Rotate right with immediate amount 0 is a one-bit rotate through carry: operand_o={carry_i, rm_i[31:1]} and carry_o=rm_i[0].
- R9: With field_i[4]=1 the amount is rs_i[4:0]; rs_i[31:5] has no effect. A nonzero amount follows R3 and R4.
- R10: With field_i[4]=1 and rs_i[4:0]=0, operand_o=rm_i and carry_o=carry_i for every shift kind.
- R11: not_shift_o is 1 exactly when imm_sel_i=0, field_i[4]=1 and field_i[7]=1. In that case operand_o still follows the register-amount rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| field_i | input | 12 | Operand field of the instruction |
| imm_sel_i | input | 1 | 1 selects the rotated-literal form |
| rm_i | input | 32 | Value of the register to be shifted |
| rs_i | input | 32 | Value of the register holding the amount |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Generated second operand |
| carry_o | output | 1 | Shifter carry-out |
| not_shift_o | output | 1 | Field belongs to a multiply or undefined encoding |

## Verification
Hand-computed vectors test each shift kind with patterns chosen so that a wrong direction, a zero fill in place of a sign fill, or a missing wrap-around gives a different word. They also use carry inputs that differ from the expected carry-out, so that passing the carry through is told apart from generating it. A sweep covers all 32 immediate amounts and all 32 register amounts for each kind, on two asymmetric words, with noisy upper `rs_i` bits. This separates the zero-amount meanings from the ordinary shifts and shows whether the upper amount bits leak in. A second sweep goes through all sixteen rotate counts on two literals, which checks both the doubling of the count and the rule for the carry.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    ACT_PASS,
    ACT_SHIFT,
    ACT_RRX,
    ACT_FILL
  } shift_act_e;
endpackage

// File: rtl/opsh_lit_rot.sv
module opsh_lit_rot #(
  parameter int DATA_W = 32,
  parameter int LIT_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [LIT_W-1:0]  lit_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] value_o,
  output logic              carry_o
);
  logic [DATA_W-1:0] stage [ROT_W+1];

  assign stage[0] = {{(DATA_W-LIT_W){1'b0}}, lit_i};

  // rotate count is doubled: stage k rotates by 2^(k+1)
  for (genvar k = 0; k < ROT_W; k++) begin : g_stage
    localparam int SH = 2 << k;
    assign stage[k+1] = rot_i[k] ? {stage[k][SH-1:0], stage[k][DATA_W-1:SH]} : stage[k];
  end

  assign value_o = stage[ROT_W];
  assign carry_o = (rot_i != '0) ? value_o[DATA_W-1] : carry_i;
endmodule

// File: rtl/opsh_decode.sv
module opsh_decode
  import opsh_pkg::*;
#(
  parameter int AMT_W = 5
) (
  input  logic             reg_amt_i,
  input  logic [AMT_W-1:0] imm_amt_i,
  input  logic [AMT_W-1:0] rs_amt_i,
  input  shift_kind_e      kind_i,
  output logic [AMT_W-1:0] amt_o,
  output shift_act_e       act_o
);
  always_comb begin
    amt_o = reg_amt_i ? rs_amt_i : imm_amt_i;
    if (amt_o != '0)   act_o = ACT_SHIFT;
    else if (reg_amt_i) act_o = ACT_PASS;
    else begin
      unique case (kind_i)
        SH_LSL:         act_o = ACT_PASS;
        SH_LSR, SH_ASR: act_o = ACT_FILL;
        default:        act_o = ACT_RRX;
      endcase
    end
  end
endmodule

// File: rtl/opsh_barrel.sv
module opsh_barrel
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  shift_kind_e       kind_i,
  output logic [DATA_W-1:0] value_o,
  output logic              carry_o
);
  // one guard bit beside the word captures the last bit shifted out
  logic [DATA_W:0]          left_w, right_w;
  logic signed [DATA_W:0]   sgn_w;
  logic [2*DATA_W-1:0]      dbl_w;

  always_comb begin
    left_w  = {1'b0, data_i} << amt_i;
    sgn_w   = $signed({data_i, 1'b0});
    right_w = {data_i, 1'b0} >> amt_i;
    dbl_w   = {data_i, data_i} >> amt_i;
    unique case (kind_i)
      SH_LSL: begin
        value_o = left_w[DATA_W-1:0];
        carry_o = left_w[DATA_W];
      end
      SH_LSR: begin
        value_o = right_w[DATA_W:1];
        carry_o = right_w[0];
      end
      SH_ASR: begin
        right_w = sgn_w >>> amt_i;
        value_o = right_w[DATA_W:1];
        carry_o = right_w[0];
      end
      default: begin
        value_o = dbl_w[DATA_W-1:0];
        carry_o = dbl_w[DATA_W-1];
      end
    endcase
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [11:0]       field_i,
  input  logic              imm_sel_i,
  input  logic [DATA_W-1:0] rm_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] operand_o,
  output logic              carry_o,
  output logic              not_shift_o
);
  localparam int AMT_W    = $clog2(DATA_W);
  localparam int LIT_W    = 8;
  localparam int ROT_W    = 4;
  localparam int B_REGAMT = 4;
  localparam int B_GAP    = 7;

  logic [DATA_W-1:0] lit_val, sh_val;
  logic              lit_c, sh_c;
  logic [AMT_W-1:0]  amt;
  shift_act_e        act;
  shift_kind_e       kind;
  logic              unused_bits;

  assign kind        = shift_kind_e'(field_i[6:5]);
  assign unused_bits = ^{rs_i[DATA_W-1:AMT_W], field_i[3:0]};

  opsh_lit_rot #(.DATA_W(DATA_W), .LIT_W(LIT_W), .ROT_W(ROT_W)) u_lit (
    .lit_i   (field_i[LIT_W-1:0]),
    .rot_i   (field_i[11:8]),
    .carry_i (carry_i),
    .value_o (lit_val),
    .carry_o (lit_c)
  );

  opsh_decode #(.AMT_W(AMT_W)) u_dec (
    .reg_amt_i (field_i[B_REGAMT]),
    .imm_amt_i (field_i[11:7]),
    .rs_amt_i  (rs_i[AMT_W-1:0]),
    .kind_i    (kind),
    .amt_o     (amt),
    .act_o     (act)
  );

  opsh_barrel #(.DATA_W(DATA_W)) u_bar (
    .data_i  (rm_i),
    .amt_i   (amt),
    .kind_i  (kind),
    .value_o (sh_val),
    .carry_o (sh_c)
  );

  always_comb begin
    if (imm_sel_i) begin
      operand_o = lit_val;
      carry_o   = lit_c;
    end else begin
      unique case (act)
        ACT_SHIFT: begin
          operand_o = sh_val;
          carry_o   = sh_c;
        end
        ACT_RRX: begin
          operand_o = {carry_i, rm_i[DATA_W-1:1]};
          carry_o   = rm_i[0];
        end
        ACT_FILL: begin
          // shift by full width: sign fill for arithmetic, zero for logical
          operand_o = (kind == SH_ASR) ? {DATA_W{rm_i[DATA_W-1]}} : '0;
          carry_o   = rm_i[DATA_W-1];
        end
        default: begin
          operand_o = rm_i;
          carry_o   = carry_i;
        end
      endcase
    end
  end

  assign not_shift_o = ~imm_sel_i & field_i[B_REGAMT] & field_i[B_GAP];
endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
  parameter int DATA_W = 32
) (
  input logic [11:0]       field_i,
  input logic              imm_sel_i,
  input logic [DATA_W-1:0] rm_i,
  input logic [DATA_W-1:0] rs_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] operand_o,
  input logic              carry_o,
  input logic              not_shift_o
);
  logic imm_amt0, reg_amt0, unused_rs;
  assign imm_amt0  = !imm_sel_i && !field_i[4] && field_i[11:7] == 5'd0;
  assign reg_amt0  = !imm_sel_i && field_i[4] && rs_i[4:0] == 5'd0;
  assign unused_rs = ^rs_i[DATA_W-1:5];

  always_comb begin
    if (imm_sel_i && field_i[11:8] == 4'd0)
      AST_IMM_ROT0_PASS: assert (operand_o == {{(DATA_W-8){1'b0}}, field_i[7:0]} && carry_o == carry_i); // R2
    if (imm_sel_i && field_i[11:8] != 4'd0)
      AST_IMM_CARRY_MSB: assert (carry_o == operand_o[DATA_W-1]); // R2
    if (imm_amt0 && field_i[6:5] == 2'b00)
      AST_LSL0_PASS: assert (operand_o == rm_i && carry_o == carry_i); // R5
    if (imm_amt0 && field_i[6:5] == 2'b01)
      AST_LSR0_ZERO: assert (operand_o == '0 && carry_o == rm_i[DATA_W-1]); // R6
    if (imm_amt0 && field_i[6:5] == 2'b10)
      AST_ASR0_FILL: assert (operand_o == {DATA_W{rm_i[DATA_W-1]}} && carry_o == rm_i[DATA_W-1]); // R7
    if (imm_amt0 && field_i[6:5] == 2'b11)
      AST_RRX_ONE_BIT: assert (operand_o == {carry_i, rm_i[DATA_W-1:1]} && carry_o == rm_i[0]); // R8
    if (reg_amt0)
      AST_REG_ZERO_PASS: assert (operand_o == rm_i && carry_o == carry_i); // R10
    if (!imm_sel_i && field_i[4] && rs_i[4:0] != 5'd0 && field_i[6:5] == 2'b11)
      AST_ROR_CARRY_MSB: assert (carry_o == operand_o[DATA_W-1]); // R4
    if (not_shift_o)
      AST_FLAG_SCOPE: assert (!imm_sel_i && field_i[4]); // R11
  end
endmodule

bind operand_shifter operand_shifter_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/operand_shifter_tb_top.sv
module operand_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] field;
  logic        imm_sel;
  logic [31:0] rm, rs;
  logic        cin;
  logic [31:0] op;
  logic        cout, ns;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk; // 125 MHz

  operand_shifter dut_i (
    .field_i(field), .imm_sel_i(imm_sel), .rm_i(rm), .rs_i(rs), .carry_i(cin),
    .operand_o(op), .carry_o(cout), .not_shift_o(ns)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        imm;
    logic [11:0] fld;
    logic [31:0] rm;
    logic [31:0] rs;
    logic        cin;
    logic [31:0] e_op;
    logic        e_c;
    logic        e_ns;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{8'd1,  1'b1, 12'h4FF, 32'h0,         32'h0,         1'b0, 32'hFF00_0000, 1'b1, 1'b0}, // R1 ror 8
    '{8'd2,  1'b1, 12'h0AB, 32'h0,         32'h0,         1'b1, 32'h0000_00AB, 1'b1, 1'b0}, // R2 rot 0 keeps carry
    '{8'd2,  1'b1, 12'hF3F, 32'h0,         32'h0,         1'b1, 32'h0000_00FC, 1'b0, 1'b0}, // R2 rot 15
    '{8'd1,  1'b1, 12'h103, 32'h0,         32'h0,         1'b0, 32'hC000_0000, 1'b1, 1'b0}, // R1 wrap
    '{8'd3,  1'b0, 12'h200, 32'h1234_5678, 32'h0,         1'b0, 32'h2345_6780, 1'b1, 1'b0}, // R3 lsl 4
    '{8'd3,  1'b0, 12'h420, 32'h8000_00FF, 32'h0,         1'b0, 32'h0080_0000, 1'b1, 1'b0}, // R3 lsr 8
    '{8'd4,  1'b0, 12'h240, 32'hF000_0008, 32'h0,         1'b0, 32'hFF00_0000, 1'b1, 1'b0}, // R4 asr 4
    '{8'd4,  1'b0, 12'h660, 32'h1234_5678, 32'h0,         1'b1, 32'h6781_2345, 1'b0, 1'b0}, // R4 ror 12
    '{8'd5,  1'b0, 12'h000, 32'hDEAD_BEEF, 32'h0,         1'b1, 32'hDEAD_BEEF, 1'b1, 1'b0}, // R5
    '{8'd5,  1'b0, 12'h00F, 32'h0000_0001, 32'h0,         1'b0, 32'h0000_0001, 1'b0, 1'b0}, // R5
    '{8'd6,  1'b0, 12'h020, 32'h8000_0001, 32'h0,         1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R6
    '{8'd7,  1'b0, 12'h040, 32'h8000_0000, 32'h0,         1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0}, // R7 neg
    '{8'd7,  1'b0, 12'h040, 32'h7FFF_FFFF, 32'h0,         1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R7 pos
    '{8'd8,  1'b0, 12'h060, 32'h0000_0003, 32'h0,         1'b1, 32'h8000_0001, 1'b1, 1'b0}, // R8
    '{8'd8,  1'b0, 12'h060, 32'h0000_0002, 32'h0,         1'b0, 32'h0000_0001, 1'b0, 1'b0}, // R8
    '{8'd9,  1'b0, 12'h330, 32'h0000_00F8, 32'hFFFF_FF04, 1'b0, 32'h0000_000F, 1'b1, 1'b0}, // R9 upper rs ignored
    '{8'd9,  1'b0, 12'h370, 32'h0000_0001, 32'h0000_001F, 1'b1, 32'h0000_0002, 1'b0, 1'b0}, // R9 ror 31
    '{8'd9,  1'b0, 12'h310, 32'h8000_0000, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R9 lsl 1
    '{8'd10, 1'b0, 12'h370, 32'h0000_0001, 32'h0000_0100, 1'b0, 32'h0000_0001, 1'b0, 1'b0}, // R10 ror
    '{8'd10, 1'b0, 12'h350, 32'h8000_0000, 32'h0000_0020, 1'b1, 32'h8000_0000, 1'b1, 1'b0}, // R10 asr
    '{8'd11, 1'b0, 12'h090, 32'h0000_0001, 32'h0000_0004, 1'b0, 32'h0000_0010, 1'b0, 1'b1}, // R11 flagged
    '{8'd11, 1'b1, 12'h090, 32'h0,         32'h0,         1'b1, 32'h0000_0090, 1'b1, 1'b0}  // R11 imm form
  };

  // reference built from the requirements, bit by bit: {ns, carry, operand}
  function automatic logic [33:0] model(logic i_imm, logic [11:0] f, logic [31:0] x,
                                         logic [31:0] s, logic c);
    logic [31:0] v, lit;
    logic        co;
    int          n;
    v = '0;
    co = c;
    if (i_imm) begin
      lit = {24'h0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int i = 0; i < 32; i++) v[i] = lit[(i + n) % 32];
      co = (n == 0) ? c : v[31];
      return {1'b0, co, v};
    end
    n = f[4] ? int'(s[4:0]) : int'(f[11:7]);
    if (n == 0) begin
      if (f[4] || f[6:5] == 2'b00) return {f[4] & f[7], c, x};
      if (f[6:5] == 2'b11) return {1'b0, x[0], c, x[31:1]};
      n = 32;
    end
    for (int i = 0; i < 32; i++) begin
      case (f[6:5])
        2'b00: v[i] = (i - n >= 0) ? x[i - n] : 1'b0;
        2'b01: v[i] = (i + n < 32) ? x[i + n] : 1'b0;
        2'b10: v[i] = (i + n < 32) ? x[i + n] : x[31];
        default: v[i] = x[(i + n) % 32];
      endcase
    end
    co = (f[6:5] == 2'b00) ? x[32 - n] : x[n - 1];
    return {f[4] & f[7], co, v};
  endfunction

  task automatic apply(logic i_imm, logic [11:0] f, logic [31:0] x, logic [31:0] s, logic c);
    @(negedge clk);
    {imm_sel, field, rm, rs, cin} = {i_imm, f, x, s, c};
    #2;
  endtask

  task automatic check(string req, logic [31:0] e_op, logic e_c, logic e_ns);
    n_vec++;
    if (op !== e_op || cout !== e_c || ns !== e_ns) begin
      n_bad++;
      $display("FAIL %s: op=%h c=%b ns=%b expected op=%h c=%b ns=%b",
               req, op, cout, ns, e_op, e_c, e_ns);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    logic [33:0] exp_v;
    logic [31:0] words [2];
    words[0] = 32'hA5C3_0F96;
    words[1] = 32'h4D21_B7E8;
    {imm_sel, field, rm, rs, cin} = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R5 reset state", 32'h0, 1'b0, 1'b0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].imm, VECS[k].fld, VECS[k].rm, VECS[k].rs, VECS[k].cin);
      check($sformatf("R%0d table %0d", VECS[k].req, k), VECS[k].e_op, VECS[k].e_c, VECS[k].e_ns);
    end

    // R3 R4 R5 R6 R7 R8: every immediate amount per kind
    for (int w = 0; w < 2; w++)
      for (int t = 0; t < 4; t++)
        for (int a = 0; a < 32; a++) begin
          logic [11:0] f;
          f = {a[4:0], t[1:0], 1'b0, 4'h0};
          apply(1'b0, f, words[w], 32'h0, w[0]);
          exp_v = model(1'b0, f, words[w], 32'h0, w[0]);
          check("R3 imm-amount sweep", exp_v[31:0], exp_v[32], exp_v[33]);
        end

    // R9 R10: every register amount per kind, noisy upper rs bits
    for (int w = 0; w < 2; w++)
      for (int t = 0; t < 4; t++)
        for (int a = 0; a < 32; a++) begin
          logic [11:0] f;
          logic [31:0] s;
          f = {4'h2, 1'b0, t[1:0], 1'b1, 4'h1};
          s = {27'h5A5_A5A5 ^ 27'(a * 977), a[4:0]};
          apply(1'b0, f, words[w], s, ~w[0]);
          exp_v = model(1'b0, f, words[w], s, ~w[0]);
          check("R9 reg-amount sweep", exp_v[31:0], exp_v[32], exp_v[33]);
        end

    // R1 R2: every rotate count
    for (int l = 0; l < 2; l++)
      for (int r = 0; r < 16; r++) begin
        logic [11:0] f;
        f = {r[3:0], (l == 0) ? 8'hC1 : 8'h7E};
        apply(1'b1, f, words[l], words[1-l], 1'b1);
        exp_v = model(1'b1, f, words[l], words[1-l], 1'b1);
        check("R1 rotate sweep", exp_v[31:0], exp_v[32], exp_v[33]);
      end

    // R11: flag raised with each shift kind, operand still a register shift
    for (int t = 0; t < 4; t++) begin
      logic [11:0] f;
      f = {4'h7, 1'b1, t[1:0], 1'b1, 4'h9};
      apply(1'b0, f, words[0], 32'h0000_0003, 1'b0);
      exp_v = model(1'b0, f, words[0], 32'h0000_0003, 1'b0);
      check("R11 flag sweep", exp_v[31:0], exp_v[32], 1'b1);
    end

    finish_run();
  end
endmodule